// File: doc/BRIEF.md
# Wave Branch Resolver

This block settles whole-wave control flow for a wide single-instruction, multiple-lane wave. Each branch instruction arrives with an opcode, a target address held as an immediate, the current program counter, and an operand. For the two scalar opcodes the operand is one scalar value. For the two mask opcodes it is a per-lane condition mask. Every lane of the wave follows the single outcome, so the block produces one taken flag and one next program counter.

A scalar value comes from one of two places: an immediate carried in the instruction, or element 0 of a vector register. Mask opcodes reduce the lane mask to one bit. That reduction looks only at lanes below the wave's active-lane count, so unused tail lanes can neither stop an all-lanes branch nor trigger an any-lane branch. The result is registered and appears one clock after the instruction is presented. It stays unchanged until the next instruction arrives.

Top module: `wave_branch_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `br_valid` high and is low otherwise. After reset, `out_valid`, `br_taken` and `next_pc` are all zero.
- R2: Opcode 0 (branch on zero) is taken when the selected scalar equals zero.
- R3: Opcode 1 (branch on nonzero) is taken when the selected scalar differs from zero.
- R4: With `use_imm` = 1 the scalar is `imm_val`. With `use_imm` = 0 it is `vec_lane0`. The unselected source has no effect on the decision.
- R5: Opcode 2 (all lanes) is taken when every lane with index below `lane_count` has its `lane_mask` bit set. Lanes at or above that count are ignored, and a count of `LANES` or more enables every lane.
- R6: Opcode 3 (any lane) is taken when at least one lane with index below `lane_count` has its `lane_mask` bit set. Mask bits of lanes at or above the count are ignored.
- R7: When the branch is taken, `next_pc` equals `target_pc`.
- R8: When the branch is not taken, `next_pc` equals `cur_pc + 1`, wrapping modulo 2^PC_W.
- R9: In a cycle with `br_valid` low, `br_taken` and `next_pc` keep their values, whatever the other inputs do.
- R10: With `lane_count` = 0, opcode 2 is taken (no active lane fails the test) and opcode 3 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch instruction is presented this cycle |
| br_op | input | 2 | Opcode: 0 zero, 1 nonzero, 2 all lanes, 3 any lane |
| use_imm | input | 1 | Scalar source select: 1 immediate, 0 vector element 0 |
| imm_val | input | DATA_W | Immediate scalar operand |
| vec_lane0 | input | DATA_W | Element 0 of the vector register operand |
| lane_mask | input | LANES | Per-lane condition mask |
| lane_count | input | CNT_W | Number of active lanes, counted from lane 0 |
| cur_pc | input | PC_W | Program counter of the branch instruction |
| target_pc | input | PC_W | Immediate branch target |
| out_valid | output | 1 | Registered result is fresh |
| br_taken | output | 1 | Registered branch decision |
| next_pc | output | PC_W | Registered next program counter |

## Verification
The bench builds the block with `LANES` = 8, `PC_W` = 8 and `DATA_W` = 16. With 8 lanes every boundary of the active-lane count can be reached: zero, a partial count, exactly full, and counts up to 15 that exceed the lane total and must saturate. An 8-bit program counter lets the wrap from 255 to 0 on a fall-through be driven directly. A 16-bit scalar is wide enough to confirm that the unselected source is ignored.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

  typedef enum logic [1:0] {
    BR_ZERO    = 2'd0,
    BR_NONZERO = 2'd1,
    BR_ALL     = 2'd2,
    BR_ANY     = 2'd3
  } br_op_e;

endpackage

// File: rtl/wbr_scalar_test.sv
module wbr_scalar_test #(
  parameter int DATA_W = 32
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] vec_lane0,
  output logic              is_zero
);

  logic [DATA_W-1:0] operand;

  always_comb begin
    operand = use_imm ? imm_val : vec_lane0;
    is_zero = (operand == '0);
  end

endmodule

// File: rtl/wbr_mask_reduce.sv
module wbr_mask_reduce #(
  parameter int LANES = 32,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] lane_mask,
  input  logic [CNT_W-1:0] lane_count,
  output logic             all_set,
  output logic             any_set
);

  logic [LANES-1:0] lane_en;

  // Lane g is enabled when the active count exceeds its index; counts
  // above LANES naturally enable every lane.
  for (genvar g = 0; g < LANES; g++) begin : g_en
    assign lane_en[g] = (lane_count > CNT_W'(g));
  end

  always_comb begin
    all_set = &(lane_mask | ~lane_en);
    any_set = |(lane_mask & lane_en);
  end

endmodule

// File: rtl/wbr_decide.sv
module wbr_decide
  import wbr_pkg::*;
(
  input  logic [1:0] br_op,
  input  logic       scalar_zero,
  input  logic       all_set,
  input  logic       any_set,
  output logic       take
);

  br_op_e op;

  always_comb begin
    op = br_op_e'(br_op);
    unique case (op)
      BR_ZERO:    take = scalar_zero;
      BR_NONZERO: take = ~scalar_zero;
      BR_ALL:     take = all_set;
      BR_ANY:     take = any_set;
      default:    take = 1'b0;
    endcase
  end

endmodule

// File: rtl/wave_branch_unit.sv
module wave_branch_unit #(
  parameter int LANES  = 32,
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [1:0]        br_op,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] vec_lane0,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [CNT_W-1:0]  lane_count,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   target_pc,
  output logic              out_valid,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  logic            scalar_zero;
  logic            all_set;
  logic            any_set;
  logic            take_d;
  logic [PC_W-1:0] pc_d;
  logic            res_en;

  wbr_scalar_test #(.DATA_W(DATA_W)) u_scalar (
    .use_imm   (use_imm),
    .imm_val   (imm_val),
    .vec_lane0 (vec_lane0),
    .is_zero   (scalar_zero)
  );

  wbr_mask_reduce #(.LANES(LANES), .CNT_W(CNT_W)) u_reduce (
    .lane_mask  (lane_mask),
    .lane_count (lane_count),
    .all_set    (all_set),
    .any_set    (any_set)
  );

  wbr_decide u_decide (
    .br_op       (br_op),
    .scalar_zero (scalar_zero),
    .all_set     (all_set),
    .any_set     (any_set),
    .take        (take_d)
  );

  // next-state
  always_comb begin
    res_en = br_valid;
    pc_d   = take_d ? target_pc : (cur_pc + PC_STEP);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      br_taken  <= 1'b0;
      next_pc   <= '0;
    end else begin
      out_valid <= br_valid;
      if (res_en) begin
        br_taken <= take_d;
        next_pc  <= pc_d;
      end
    end
  end

endmodule

// File: rtl/wbr_checker.sv
module wbr_checker #(
  parameter int LANES  = 32,
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [1:0]        br_op,
  input logic              use_imm,
  input logic [DATA_W-1:0] imm_val,
  input logic [LANES-1:0]  lane_mask,
  input logic [PC_W-1:0]   cur_pc,
  input logic [PC_W-1:0]   target_pc,
  input logic              out_valid,
  input logic              br_taken,
  input logic [PC_W-1:0]   next_pc
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !out_valid); // R1
  AST_ZERO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_op == 2'd0 && use_imm && imm_val == '0) |=> br_taken); // R2
  AST_NONZERO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_op == 2'd1 && use_imm && imm_val == '0) |=> !br_taken); // R3
  AST_ALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_op == 2'd2 && lane_mask == '1) |=> br_taken); // R5
  AST_ANY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_op == 2'd3 && lane_mask == '0) |=> !br_taken); // R6
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (!br_taken || next_pc == $past(target_pc))); // R7
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (br_taken || next_pc == PC_W'($past(cur_pc) + PC_W'(1)))); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> ($stable(br_taken) && $stable(next_pc))); // R9

endmodule

bind wave_branch_unit wbr_checker #(
  .LANES(LANES), .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_wbr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_valid  (br_valid),
  .br_op     (br_op),
  .use_imm   (use_imm),
  .imm_val   (imm_val),
  .lane_mask (lane_mask),
  .cur_pc    (cur_pc),
  .target_pc (target_pc),
  .out_valid (out_valid),
  .br_taken  (br_taken),
  .next_pc   (next_pc)
);

// File: tb/wave_branch_unit_bench.sv
`timescale 1ns/1ps
module wave_branch_unit_bench;

  localparam int LANES  = 8;
  localparam int PC_W   = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam int NVEC   = 18;

  typedef struct packed {
    logic [1:0]  op;
    logic        sel;
    logic [15:0] imm;
    logic [15:0] lane0;
    logic [7:0]  mask;
    logic [3:0]  cnt;
    logic [7:0]  pc;
    logic [7:0]  tgt;
    logic        exp_take;
  } vec_t;

  // op, use_imm, imm, lane0, mask, count, pc, target, expected taken
  localparam vec_t TBL [NVEC] = '{
    '{2'd0, 1'b1, 16'h0000, 16'h1234, 8'h00, 4'd8,  8'd10,  8'd50,  1'b1},
    '{2'd0, 1'b1, 16'h0005, 16'h0000, 8'h00, 4'd8,  8'd11,  8'd51,  1'b0},
    '{2'd1, 1'b1, 16'h0005, 16'h0000, 8'h00, 4'd8,  8'd12,  8'd52,  1'b1},
    '{2'd1, 1'b1, 16'h0000, 16'h7777, 8'h00, 4'd8,  8'd13,  8'd53,  1'b0},
    '{2'd0, 1'b0, 16'h0007, 16'h0000, 8'h00, 4'd8,  8'd14,  8'd54,  1'b1},
    '{2'd1, 1'b0, 16'h0007, 16'h0000, 8'h00, 4'd8,  8'd15,  8'd55,  1'b0},
    '{2'd0, 1'b1, 16'h0000, 16'h0003, 8'h00, 4'd8,  8'd16,  8'd56,  1'b1},
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 8'hFF, 4'd8,  8'd17,  8'd57,  1'b1},
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 8'h7F, 4'd8,  8'd18,  8'd58,  1'b0},
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 8'h0F, 4'd4,  8'd19,  8'd59,  1'b1},
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 8'h0F, 4'd5,  8'd20,  8'd60,  1'b0},
    '{2'd3, 1'b1, 16'h0000, 16'h0000, 8'h00, 4'd8,  8'd21,  8'd61,  1'b0},
    '{2'd3, 1'b1, 16'h0000, 16'h0000, 8'h80, 4'd8,  8'd22,  8'd62,  1'b1},
    '{2'd3, 1'b1, 16'h0000, 16'h0000, 8'h80, 4'd7,  8'd23,  8'd63,  1'b0},
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 8'h00, 4'd0,  8'd24,  8'd64,  1'b1},
    '{2'd3, 1'b1, 16'h0000, 16'h0000, 8'hFF, 4'd0,  8'd25,  8'd65,  1'b0},
    '{2'd2, 1'b1, 16'h0000, 16'h0000, 8'h0F, 4'd15, 8'd26,  8'd66,  1'b0},
    '{2'd0, 1'b1, 16'h0001, 16'h0000, 8'h00, 4'd8,  8'd255, 8'd70,  1'b0}
  };

  localparam string TAG [NVEC] = '{
    "R2", "R2", "R3", "R3", "R4", "R4", "R4", "R5", "R5",
    "R5", "R5", "R6", "R6", "R6", "R10", "R10", "R5", "R8"
  };

  logic              clk;
  logic              rst_n;
  logic              br_valid;
  logic [1:0]        br_op;
  logic              use_imm;
  logic [DATA_W-1:0] imm_val;
  logic [DATA_W-1:0] vec_lane0;
  logic [LANES-1:0]  lane_mask;
  logic [CNT_W-1:0]  lane_count;
  logic [PC_W-1:0]   cur_pc;
  logic [PC_W-1:0]   target_pc;
  logic              out_valid;
  logic              br_taken;
  logic [PC_W-1:0]   next_pc;

  int n_chk  = 0;
  int n_fail = 0;

  wave_branch_unit #(.LANES(LANES), .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W))
  u_wave_branch_unit (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_op(br_op),
    .use_imm(use_imm), .imm_val(imm_val), .vec_lane0(vec_lane0),
    .lane_mask(lane_mask), .lane_count(lane_count), .cur_pc(cur_pc),
    .target_pc(target_pc), .out_valid(out_valid), .br_taken(br_taken),
    .next_pc(next_pc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    br_op      = v.op;
    use_imm    = v.sel;
    imm_val    = v.imm;
    vec_lane0  = v.lane0;
    lane_mask  = v.mask;
    lane_count = v.cnt;
    cur_pc     = v.pc;
    target_pc  = v.tgt;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic       exp_t;
    logic [7:0] exp_pc;
    logic [7:0] held_pc;
    logic       held_t;
    rst_n    = 1'b0;
    br_valid = 1'b0;
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R1", "reset br_taken", 32'(br_taken), 32'd0);
    chk("R1", "reset next_pc", 32'(next_pc), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle out_valid", 32'(out_valid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i]);
      br_valid = 1'b1;
      @(negedge clk);
      br_valid = 1'b0;
      exp_t  = TBL[i].exp_take;
      exp_pc = exp_t ? TBL[i].tgt : 8'(TBL[i].pc + 8'd1);
      chk("R1", "out_valid after issue", 32'(out_valid), 32'd1);
      chk(TAG[i], "br_taken", 32'(br_taken), 32'(exp_t));
      chk(exp_t ? "R7" : "R8", "next_pc", 32'(next_pc), 32'(exp_pc));
    end

    // R9: hold with scrambled inputs and br_valid low
    held_t  = br_taken;
    held_pc = next_pc;
    drive('{2'd3, 1'b1, 16'hFFFF, 16'hFFFF, 8'hFF, 4'd8, 8'd99, 8'd200, 1'b1});
    @(negedge clk);
    chk("R1", "out_valid idle", 32'(out_valid), 32'd0);
    chk("R9", "held br_taken", 32'(br_taken), 32'(held_t));
    chk("R9", "held next_pc", 32'(next_pc), 32'(held_pc));
    @(negedge clk);
    chk("R9", "held next_pc later", 32'(next_pc), 32'(held_pc));

    // back-to-back issues: each result lands one clock later (R1, R7, R8)
    drive('{2'd3, 1'b1, 16'h0000, 16'h0000, 8'h01, 4'd1, 8'd30, 8'd90, 1'b1});
    br_valid = 1'b1;
    @(negedge clk);
    chk("R7", "b2b first next_pc", 32'(next_pc), 32'd90);
    drive('{2'd1, 1'b0, 16'h0009, 16'h0000, 8'h00, 4'd8, 8'd40, 8'd91, 1'b0});
    @(negedge clk);
    br_valid = 1'b0;
    chk("R4", "b2b second br_taken", 32'(br_taken), 32'd0);
    chk("R8", "b2b second next_pc", 32'(next_pc), 32'd41);
    chk("R1", "b2b out_valid", 32'(out_valid), 32'd1);

    // R1: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "re-reset next_pc", 32'(next_pc), 32'd0);
    chk("R1", "re-reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule